// File: doc/BRIEF.md
# Outer-Product Lane Mask Generator

This block decodes the 64-bit parameter word of a 16-bit multiply-accumulate outer-product operation. It returns the X and Y byte offsets, the Z row offset and the control flags (overwrite instead of accumulate, skip of either input, wide 32-bit results, single-row vector mode). From two 7-bit disable fields it builds a 32-lane row enable mask and a 32-lane column enable mask. From the row mask, the Z offset and the result width it works out which of the 64 Z rows the arithmetic will write, and which of those rows must be cleared first.

The decode is pure combinational logic followed by one register stage. The register stage is a two-state machine. In `OUT_EMPTY`, `out_valid` is low. The `LOAD` transition, taken on any cycle with `in_valid` high, enters or stays in `OUT_LOADED` and captures a fresh decode. The `DRAIN` transition, taken on a cycle with `in_valid` low, returns to `OUT_EMPTY`. In `OUT_EMPTY` the data outputs keep their last captured values.

The lane disable field has its own compact encoding. It can enable all lanes, only the odd lanes, only the even lanes, one selected lane, a leading run of lanes or a trailing run of lanes.

Top module: `outer_lane_decode`

## Requirements
- R1: `x_off` equals word bits 8..0, `y_off` equals bits 18..10, and `z_row` equals bits 25..20.
- R2: `acc_overwrite` is bit 27, `skip_y` is bit 28, `skip_x` is bit 29, `wide_out` is bit 62 and `vec_mode` is bit 63.
- R3: A disable field of 0, or any value from 3 to 31, enables all 32 lanes.
- R4: A disable field of 1 enables only the odd lanes (mask 0xAAAAAAAA). A field of 2 enables only the even lanes (mask 0x55555555).
- R5: When field bits 6..5 are 01, only lane k is enabled, where k is field bits 4..0.
- R6: When field bits 6..5 are 10, lanes 0 to N-1 are enabled, where N is field bits 4..0. N = 0 enables no lane.
- R7: When field bits 6..5 are 11, lanes 32-N to 31 are enabled. N = 0 enables no lane.
- R8: `row_mask` is decoded from word bits 38..32 and `col_mask` from bits 47..41. The two decodes are independent of each other.
- R9: With bits 62 and 63 both clear, `zwr_rows` bit r is set exactly when some enabled row lane j has r = (z_row + 2j) mod 64.
- R10: With bit 62 set and bit 63 clear, each enabled row lane j sets rows (z_row + 2j) mod 64 and (z_row + 2j + 1) mod 64.
- R11: With bit 63 set, `zwr_rows` has only bit `z_row` set, whatever the width and masks.
- R12: `zclr_rows` equals `zwr_rows` when bit 27 is set, and is zero otherwise.
- R13: Outputs change one clock after a word is accepted. `out_valid` follows `in_valid` one cycle late. Data outputs hold while `in_valid` is low. Reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Parameter word present this cycle |
| param_word | input | 64 | Operation parameter word |
| out_valid | output | 1 | Registered decode valid |
| x_off | output | 9 | X byte offset |
| y_off | output | 9 | Y byte offset |
| z_row | output | 6 | Z row offset |
| acc_overwrite | output | 1 | Overwrite Z instead of accumulating |
| skip_x | output | 1 | Skip X input |
| skip_y | output | 1 | Skip Y input |
| wide_out | output | 1 | 32-bit result mode |
| vec_mode | output | 1 | Single-row vector mode |
| row_mask | output | 32 | Row lane enables |
| col_mask | output | 32 | Column lane enables |
| zwr_rows | output | 64 | Z rows written |
| zclr_rows | output | 64 | Z rows cleared before writing |

## Verification
The assertions take for granted that `in_valid` and `param_word` are stable, known values at each rising edge, and that reset is held for at least one edge before the first word. They also rely on every bit pattern of the word being legal, so unused bits are never constrained. The stimulus changes inputs only on the falling edge, drives fully known words, and biases the two disable fields across all six encodings, including counts of 0 and 31. It also places Z offsets near 63 so that row wrap-around is exercised.

// File: rtl/opmask_pkg.sv
package opmask_pkg;

    // Bit positions inside the parameter word (fixed by the operation format)
    localparam int XOFF_LSB  = 0;
    localparam int YOFF_LSB  = 10;
    localparam int ZOFF_LSB  = 20;
    localparam int OVR_BIT   = 27;
    localparam int SKIPY_BIT = 28;
    localparam int SKIPX_BIT = 29;
    localparam int ROWF_LSB  = 32;
    localparam int COLF_LSB  = 41;
    localparam int WIDE_BIT  = 62;
    localparam int VEC_BIT   = 63;

    typedef enum logic [2:0] {
        LM_ALL,
        LM_ODD,
        LM_EVEN,
        LM_ONE,
        LM_HEAD,
        LM_TAIL
    } lane_mode_e;

    typedef enum logic {
        OUT_EMPTY,
        OUT_LOADED
    } out_state_e;

endpackage

// File: rtl/lane_mask_gen.sv
module lane_mask_gen
    import opmask_pkg::*;
#(
    parameter int LANES = 32
) (
    input  logic [$clog2(LANES)+1:0] field,
    output logic [LANES-1:0]         mask
);
    localparam int IW = $clog2(LANES);
    localparam int FW = IW + 2;
    localparam int CW = IW + 2;

    lane_mode_e      mode;
    logic [IW-1:0]   count;
    logic [1:0]      sel;
    logic [CW-1:0]   cnt_ext;

    assign count   = field[IW-1:0];
    assign sel     = field[FW-1:FW-2];
    assign cnt_ext = CW'(count);

    // Field class decode
    always_comb begin
        mode = LM_ALL;
        unique case (sel)
            2'b01: mode = LM_ONE;
            2'b10: mode = LM_HEAD;
            2'b11: mode = LM_TAIL;
            default: begin
                if (field == FW'(1))
                    mode = LM_ODD;
                else if (field == FW'(2))
                    mode = LM_EVEN;
                else
                    mode = LM_ALL;
            end
        endcase
    end

    // Per-lane enable
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam logic [CW-1:0] LIDX = CW'(i);
        always_comb begin
            unique case (mode)
                LM_ALL:  mask[i] = 1'b1;
                LM_ODD:  mask[i] = (i % 2) == 1;
                LM_EVEN: mask[i] = (i % 2) == 0;
                LM_ONE:  mask[i] = (count == IW'(i));
                LM_HEAD: mask[i] = (LIDX < cnt_ext);
                LM_TAIL: mask[i] = ((LIDX + cnt_ext) >= CW'(LANES));
                default: mask[i] = 1'b1;
            endcase
        end
    end

    always_comb begin
        if (sel == 2'b01)
            AST_ONE_LANE: assert ($countones(mask) == 1); // R5
        if (sel == 2'b10)
            AST_HEAD_COUNT: assert ($countones(mask) == int'(count) && (count == '0 || mask[0])); // R6
        if (sel == 2'b11)
            AST_TAIL_COUNT: assert ($countones(mask) == int'(count) && (count == '0 || mask[LANES-1])); // R7
    end

endmodule

// File: rtl/zrow_pattern.sv
module zrow_pattern #(
    parameter int LANES = 32,
    parameter int ZROWS = 64
) (
    input  logic [LANES-1:0]         row_mask,
    input  logic [$clog2(ZROWS)-1:0] zoff,
    input  logic                     wide,
    input  logic                     vec,
    input  logic                     ovr,
    output logic [ZROWS-1:0]         zwr,
    output logic [ZROWS-1:0]         zclr
);
    localparam int ZW = $clog2(ZROWS);

    // Each row looks back at its distance from the offset (wrapping mod ZROWS)
    for (genvar r = 0; r < ZROWS; r++) begin : g_row
        logic [ZW-1:0] delta;
        logic          lane_hit;
        assign delta    = ZW'(r) - zoff;
        assign lane_hit = row_mask[delta[ZW-1:1]];
        always_comb begin
            if (vec)
                zwr[r] = (delta == '0);
            else
                zwr[r] = lane_hit && (wide || !delta[0]);
        end
    end

    assign zclr = ovr ? zwr : '0;

    always_comb begin
        AST_CLR_SUBSET: assert ((zclr & ~zwr) == '0); // R12
    end

endmodule

// File: rtl/outer_lane_decode.sv
module outer_lane_decode
    import opmask_pkg::*;
#(
    parameter int LANES = 32,
    parameter int ZROWS = 64,
    parameter int OFFW  = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [63:0]              param_word,
    output logic                     out_valid,
    output logic [OFFW-1:0]          x_off,
    output logic [OFFW-1:0]          y_off,
    output logic [$clog2(ZROWS)-1:0] z_row,
    output logic                     acc_overwrite,
    output logic                     skip_x,
    output logic                     skip_y,
    output logic                     wide_out,
    output logic                     vec_mode,
    output logic [LANES-1:0]         row_mask,
    output logic [LANES-1:0]         col_mask,
    output logic [ZROWS-1:0]         zwr_rows,
    output logic [ZROWS-1:0]         zclr_rows
);
    localparam int ZW = $clog2(ZROWS);
    localparam int FW = $clog2(LANES) + 2;

    // Combinational decode
    logic [OFFW-1:0]  x_d, y_d;
    logic [ZW-1:0]    z_d;
    logic             ovr_d, sx_d, sy_d, wide_d, vec_d;
    logic [FW-1:0]    rowf, colf;
    logic [LANES-1:0] rmask_d, cmask_d;
    logic [ZROWS-1:0] zwr_d, zclr_d;
    logic             unused_bits;

    assign x_d    = param_word[XOFF_LSB +: OFFW];
    assign y_d    = param_word[YOFF_LSB +: OFFW];
    assign z_d    = param_word[ZOFF_LSB +: ZW];
    assign ovr_d  = param_word[OVR_BIT];
    assign sy_d   = param_word[SKIPY_BIT];
    assign sx_d   = param_word[SKIPX_BIT];
    assign wide_d = param_word[WIDE_BIT];
    assign vec_d  = param_word[VEC_BIT];
    assign rowf   = param_word[ROWF_LSB +: FW];
    assign colf   = param_word[COLF_LSB +: FW];

    assign unused_bits = ^{param_word[9], param_word[19], param_word[26],
                           param_word[31:30], param_word[40:39], param_word[61:48]};

    lane_mask_gen #(.LANES(LANES)) u_rowgen (
        .field (rowf),
        .mask  (rmask_d)
    );

    lane_mask_gen #(.LANES(LANES)) u_colgen (
        .field (colf),
        .mask  (cmask_d)
    );

    zrow_pattern #(.LANES(LANES), .ZROWS(ZROWS)) u_zrow (
        .row_mask (rmask_d),
        .zoff     (z_d),
        .wide     (wide_d),
        .vec      (vec_d),
        .ovr      (ovr_d),
        .zwr      (zwr_d),
        .zclr     (zclr_d)
    );

    // Output stage state machine
    out_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OUT_EMPTY:  if (in_valid)  state_d = OUT_LOADED;   // LOAD
            OUT_LOADED: if (!in_valid) state_d = OUT_EMPTY;    // DRAIN
            default:    state_d = OUT_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= OUT_EMPTY;
        else
            state_q <= state_d;
    end

    assign out_valid = (state_q == OUT_LOADED);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_off         <= '0;
            y_off         <= '0;
            z_row         <= '0;
            acc_overwrite <= 1'b0;
            skip_x        <= 1'b0;
            skip_y        <= 1'b0;
            wide_out      <= 1'b0;
            vec_mode      <= 1'b0;
            row_mask      <= '0;
            col_mask      <= '0;
            zwr_rows      <= '0;
            zclr_rows     <= '0;
        end else if (in_valid) begin
            x_off         <= x_d;
            y_off         <= y_d;
            z_row         <= z_d;
            acc_overwrite <= ovr_d;
            skip_x        <= sx_d;
            skip_y        <= sy_d;
            wide_out      <= wide_d;
            vec_mode      <= vec_d;
            row_mask      <= rmask_d;
            col_mask      <= cmask_d;
            zwr_rows      <= zwr_d;
            zclr_rows     <= zclr_d;
        end
    end

    AST_VALID_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R13
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(row_mask) && $stable(zwr_rows))); // R13
    AST_VEC_ONE_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && vec_mode) |-> ($onehot(zwr_rows) && zwr_rows[z_row])); // R11
    AST_NARROW_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !vec_mode && !wide_out) |-> ($countones(zwr_rows) == $countones(row_mask))); // R9
    AST_WIDE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !vec_mode && wide_out) |-> ($countones(zwr_rows) == 2 * $countones(row_mask))); // R10
    AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !acc_overwrite) |-> (zclr_rows == '0)); // R12

endmodule

// File: tb/sim_outer_lane_decode.sv
`timescale 1ns/1ps
module sim_outer_lane_decode;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] param_word = '0;

    logic        out_valid, acc_overwrite, skip_x, skip_y, wide_out, vec_mode;
    logic [8:0]  x_off, y_off;
    logic [5:0]  z_row;
    logic [31:0] row_mask, col_mask;
    logic [63:0] zwr_rows, zclr_rows;

    always #2.5 clk = ~clk;

    outer_lane_decode u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .param_word(param_word),
        .out_valid(out_valid), .x_off(x_off), .y_off(y_off), .z_row(z_row),
        .acc_overwrite(acc_overwrite), .skip_x(skip_x), .skip_y(skip_y),
        .wide_out(wide_out), .vec_mode(vec_mode), .row_mask(row_mask),
        .col_mask(col_mask), .zwr_rows(zwr_rows), .zclr_rows(zclr_rows)
    );

    int n_checks = 0;
    int n_err = 0;
    bit done = 0;

    // Expected state of the registered outputs
    logic        e_valid = 0;
    logic [63:0] e_word = '0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] m_lane(input logic [6:0] f);
        logic [31:0] m = '0;
        int n = int'(f[4:0]);
        case (f[6:5])
            2'b01: m[n] = 1'b1;
            2'b10: for (int k = 0; k < n; k++) m[k] = 1'b1;
            2'b11: for (int k = 32 - n; k < 32; k++) m[k] = 1'b1;
            default: begin
                for (int k = 0; k < 32; k++) begin
                    if (f == 7'd1)      m[k] = (k % 2 == 1);
                    else if (f == 7'd2) m[k] = (k % 2 == 0);
                    else                m[k] = 1'b1;
                end
            end
        endcase
        return m;
    endfunction

    function automatic string m_tag(input logic [6:0] f);
        case (f[6:5])
            2'b01: return "R5";
            2'b10: return "R6";
            2'b11: return "R7";
            default: return (f == 7'd1 || f == 7'd2) ? "R4" : "R3";
        endcase
    endfunction

    function automatic logic [63:0] m_zwr(input logic [63:0] w);
        logic [63:0] m = '0;
        logic [31:0] rm = m_lane(w[38:32]);
        int zo = int'(w[25:20]);
        if (w[63]) m[zo] = 1'b1;
        else
            for (int j = 0; j < 32; j++)
                if (rm[j]) begin
                    m[(zo + 2*j) % 64] = 1'b1;
                    if (w[62]) m[(zo + 2*j + 1) % 64] = 1'b1;
                end
        return m;
    endfunction

    function automatic logic [63:0] mk(input int xo, input int yo, input int zo, input bit ovr,
                                       input bit sy, input bit sx, input logic [6:0] rf,
                                       input logic [6:0] cf, input bit wide, input bit vec);
        logic [63:0] w = '0;
        w[8:0] = 9'(xo); w[18:10] = 9'(yo); w[25:20] = 6'(zo);
        w[27] = ovr; w[28] = sy; w[29] = sx;
        w[38:32] = rf; w[47:41] = cf; w[62] = wide; w[63] = vec;
        return w;
    endfunction

    function automatic logic [6:0] rnd_field();
        logic [4:0] n = 5'($urandom);
        case ($urandom % 8)
            0: return 7'd0;
            1: return 7'd1;
            2: return 7'd2;
            3: return {2'b00, n};
            4: return {2'b01, n};
            5: return {2'b10, ($urandom % 4 == 0) ? 5'd0 : n};
            6: return {2'b11, ($urandom % 4 == 0) ? 5'd0 : n};
            default: return 7'($urandom);
        endcase
    endfunction

    task automatic compare();
        logic [63:0] ez, ec;
        logic [31:0] er, ecm;
        chk(out_valid == e_valid, "R13 valid", 64'(out_valid), 64'(e_valid));
        chk(x_off == e_word[8:0] && y_off == e_word[18:10] && z_row == e_word[25:20],
            "R1 offsets", {28'd0, x_off, y_off, z_row, 12'd0},
            {28'd0, e_word[8:0], e_word[18:10], e_word[25:20], 12'd0});
        chk({acc_overwrite, skip_y, skip_x, wide_out, vec_mode} ==
            {e_word[27], e_word[28], e_word[29], e_word[62], e_word[63]}, "R2 flags",
            64'({acc_overwrite, skip_y, skip_x, wide_out, vec_mode}),
            64'({e_word[27], e_word[28], e_word[29], e_word[62], e_word[63]}));
        er  = (e_word == '0 && !e_valid) ? '0 : m_lane(e_word[38:32]);
        ecm = (e_word == '0 && !e_valid) ? '0 : m_lane(e_word[47:41]);
        ez  = (e_word == '0 && !e_valid) ? '0 : m_zwr(e_word);
        ec  = e_word[27] ? ez : '0;
        chk(row_mask == er, {m_tag(e_word[38:32]), " row mask"}, 64'(row_mask), 64'(er));
        chk(col_mask == ecm, {"R8 col mask ", m_tag(e_word[47:41])}, 64'(col_mask), 64'(ecm));
        chk(zwr_rows == ez, e_word[63] ? "R11 zwr" : (e_word[62] ? "R10 zwr" : "R9 zwr"), zwr_rows, ez);
        chk(zclr_rows == ec, "R12 zclr", zclr_rows, ec);
    endtask

    // One cycle: check what the previous drive produced, then drive anew
    task automatic step(input bit v, input logic [63:0] w);
        @(negedge clk);
        compare();
        in_valid   = v;
        param_word = w;
        if (v) e_word = w;
        e_valid = v;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // Reset state (R13): all outputs zero while reset is held
        chk(out_valid == 0 && row_mask == '0 && zwr_rows == '0 && x_off == '0,
            "R13 reset", {out_valid, row_mask, zwr_rows[30:0]}, 64'd0);
        // Garbage word during reset must not appear
        in_valid = 1'b1; param_word = '1;
        @(negedge clk);
        chk(row_mask == '0 && out_valid == 0, "R13 reset hold", 64'(row_mask), 64'd0);
        in_valid = 1'b0; param_word = '0;
        rst_n = 1'b1;

        // Directed cases
        step(1, mk(9'h1FF, 0, 0, 1, 0, 0, 7'd0, 7'd0, 0, 0));        // R3 all, R12 clear
        step(1, mk(0, 9'h1FF, 5, 0, 1, 0, 7'd1, 7'd2, 0, 0));        // R4 odd/even, R8
        step(1, mk(3, 4, 63, 1, 0, 1, 7'd2, 7'd1, 1, 0));            // R10 wrap
        step(1, mk(7, 8, 1, 0, 0, 0, {2'b01, 5'd31}, {2'b01, 5'd0}, 0, 0)); // R5
        step(1, mk(1, 1, 62, 1, 0, 0, {2'b10, 5'd0}, {2'b10, 5'd31}, 0, 0)); // R6 N=0
        step(1, mk(2, 2, 33, 0, 0, 0, {2'b11, 5'd5}, {2'b11, 5'd0}, 1, 0));  // R7
        step(1, mk(5, 6, 40, 1, 1, 1, 7'd3, 7'd31, 0, 0));           // R3 3 and 31
        step(1, mk(0, 0, 17, 1, 0, 0, {2'b10, 5'd0}, 7'd0, 1, 1));   // R11 ignores mask
        step(1, mk(0, 0, 63, 0, 0, 0, 7'd0, 7'd0, 0, 1));            // R11
        step(0, '1);                                                 // R13 hold
        step(0, 64'h5555_0000_AAAA_0000);                            // R13 hold
        step(1, mk(511, 511, 63, 1, 1, 1, {2'b11, 5'd31}, 7'd1, 1, 0));

        // Randomised traffic
        for (int i = 0; i < 4000; i++) begin
            logic [63:0] w = {$urandom, $urandom};
            w[38:32] = rnd_field();
            w[47:41] = rnd_field();
            if ($urandom % 4 == 0) w[63] = 1'b0;
            step(($urandom % 5) != 0, w);
        end
        step(0, '0);
        @(negedge clk);
        compare();

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

endmodule